// File: doc/BRIEF.md
# Prescaled 8-bit Pulse-Width Modulator

This block makes a pulse-width modulated waveform from two counters. A prescaler counts down from a reload value that software sets. Each time it reaches zero it sends one advance tick to an 8-bit period counter. The period counter runs freely from 00h to FFh and wraps back to 00h. It is never loaded from any register. A separate compare value sets the length of the high phase. The compare value is only ever compared against the counter and is never copied into it.

Software writes the compare value and the prescaler reload through a one-cycle write strobe with a select bit. A new compare value first goes into a pending register. It moves into the active comparator only at a period wrap, so a period never mixes two duty settings. When the enable input is low, the output is held low and both counters stay at zero. The next rising enable then starts a clean period from count 00h.

Top module: `pwm8_gen`

## Requirements
- R1: After a synchronous reset, `pwm_out` is 0, both counters are zero, and the active compare value and the prescaler reload are both 00h.
- R2: While enabled, the period counter advances by one on each prescaler tick and wraps from FFh to 00h, so a period lasts 256 ticks.
- R3: The prescaler counts down from the reload value R. It issues a tick whenever it is at zero and enable is high. The tick spacing is therefore R+1 clocks, the PWM period is 256*(R+1) clocks, and the first tick comes in the first enabled clock.
- R4: For a compare value C from 01h to FFh, the output is high while the counter is below C and low from the count equal to C until the wrap. This gives C*(R+1) high clocks per period.
- R5: With C = 00h, the output is high only during count 00h, which is R+1 clocks per period.
- R6: With C = FFh, the output is low only during count FFh.
- R7: A compare write takes effect at the next period wrap, and the period in progress keeps its old value. A compare write made while the block is disabled is used from the first enabled period.
- R8: While `enable` is low, `pwm_out` is low and both counters are held at zero. Re-enabling starts a period at count 00h.
- R9: A write happens only in a clock where `wr_en` is 1. `wr_sel` = 0 selects the compare value and `wr_sel` = 1 selects the prescaler reload. If `wr_en` is 0, the values on `wr_data` are ignored.
- R10: `pwm_out` is registered. It reflects the counter state of the previous clock, so it rises one clock after enable goes high and falls one clock after enable goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run control; low holds counters at zero and output low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = compare value, 1 = prescaler reload |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The compare endpoints are the riskiest cases. A design that uses a plain less-than test would keep 00h low for the whole period. A design that uses less-or-equal would hold FFh high for the whole period. A sweep over all 256 compare values writes each value in the middle of the period before it. A design that updated the comparator immediately would therefore show a wrong high time in that period. Disabling in the middle of a period and then re-enabling checks that the counters restart from zero, and also checks that a write strobed off was dropped. Several reload values check that the period scales with R+1 and not with R.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  typedef enum logic {
    SEL_COMPARE = 1'b0,
    SEL_RELOAD  = 1'b1
  } pwm_reg_sel_e;
endpackage

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             wr_reload,
  input  logic [PRE_W-1:0] wr_value,
  output logic             tick
);
  localparam logic [PRE_W-1:0] ZERO = '0;

  logic [PRE_W-1:0] reload_q;
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) reload_q <= ZERO;
    else if (wr_reload) reload_q <= wr_value;
  end

  assign tick = enable && (div_q == ZERO);

  always_ff @(posedge clk) begin
    if (rst || !enable) div_q <= ZERO;
    else if (div_q == ZERO) div_q <= reload_q;
    else div_q <= div_q - 1'b1;
  end
endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] count_q;

  assign count = count_q;
  assign wrap  = tick && (count_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || !enable) count_q <= '0;
    else if (tick) count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/pwm8_compare.sv
module pwm8_compare #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             wr_compare,
  input  logic [CNT_W-1:0] wr_value,
  input  logic             wrap,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmp_active,
  output logic             pwm_out
);
  logic [CNT_W-1:0] pending_q;
  logic [CNT_W-1:0] active_q;
  logic             out_q;
  logic             high_phase;

  always_ff @(posedge clk) begin
    if (rst) pending_q <= '0;
    else if (wr_compare) pending_q <= wr_value;
  end

  // Active value moves only at a period boundary, or freely while stopped.
  always_ff @(posedge clk) begin
    if (rst) active_q <= '0;
    else if (!enable || wrap) active_q <= pending_q;
  end

  assign high_phase = (count == '0) || (count < active_q);

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else out_q <= enable && high_phase;
  end

  assign cmp_active = active_q;
  assign pwm_out    = out_q;
endmodule

// File: rtl/pwm8_gen.sv
module pwm8_gen #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   enable,
  input  logic                                   wr_en,
  input  logic                                   wr_sel,
  input  logic [((CNT_W > PRE_W) ? CNT_W : PRE_W)-1:0] wr_data,
  output logic                                   pwm_out
);
  import pwm8_pkg::*;

  pwm_reg_sel_e     sel;
  logic             wr_cmp;
  logic             wr_pre;
  logic             pre_tick;
  logic             cnt_wrap;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_act;

  assign sel    = pwm_reg_sel_e'(wr_sel);
  assign wr_cmp = wr_en && (sel == SEL_COMPARE);
  assign wr_pre = wr_en && (sel == SEL_RELOAD);

  pwm8_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .wr_reload(wr_pre),
    .wr_value (wr_data[PRE_W-1:0]),
    .tick     (pre_tick)
  );

  pwm8_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .enable(enable),
    .tick  (pre_tick),
    .count (cnt_q),
    .wrap  (cnt_wrap)
  );

  pwm8_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .wr_compare(wr_cmp),
    .wr_value  (wr_data[CNT_W-1:0]),
    .wrap      (cnt_wrap),
    .count     (cnt_q),
    .cmp_active(cmp_act),
    .pwm_out   (pwm_out)
  );
endmodule

// File: rtl/pwm8_gen_chk.sv
module pwm8_gen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_act,
  input logic             pwm_out
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!pwm_out && cnt == '0));

  assert_no_tick_off_R3: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !tick);

  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == TOP) |=> (cnt == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (enable && !tick) |=> $stable(cnt));

  assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (enable && !(tick && cnt == TOP)) |=> $stable(cmp_act));

  assert_start_high_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && cnt == '0) |=> pwm_out);

  assert_match_low_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && cnt != '0 && cnt >= cmp_act) |=> !pwm_out);
endmodule

bind pwm8_gen pwm8_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .enable (enable),
  .tick   (pre_tick),
  .cnt    (cnt_q),
  .cmp_act(cmp_act),
  .pwm_out(pwm_out)
);

// File: tb/pwm8_gen_tb_top.sv
module pwm8_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       pwm_out;

  int checks = 0;
  int fails  = 0;
  logic prev = 1'b0;

  always #5 clk = ~clk;

  pwm8_gen dut_i (
    .clk(clk), .rst(rst), .enable(enable), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [7:0] v);
    wr_sel = sel; wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise();
    forever begin
      @(negedge clk);
      if (pwm_out && !prev) begin prev = 1'b1; break; end
      prev = pwm_out;
    end
  endtask

  // Starts on the negedge where a rise was seen; ends on the next such negedge.
  task automatic measure(input bit do_wr, input logic [7:0] v, output int hi, output int n);
    hi = 1; n = 1;
    if (do_wr) begin wr_sel = 1'b0; wr_data = v; wr_en = 1'b1; end
    forever begin
      @(negedge clk);
      wr_en = 1'b0;
      if (pwm_out && !prev) begin prev = 1'b1; break; end
      prev = pwm_out;
      n++;
      if (pwm_out) hi++;
    end
  endtask

  function automatic int high_counts(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hi, n, prev_c;
    repeat (4) @(negedge clk);
    check(pwm_out == 1'b0, "R1 output low in reset", pwm_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pwm_out == 1'b0, "R1 output low after reset", pwm_out, 0);

    // R1: reset compare 00h and reload 00h -> 1 high clock in 256
    enable = 1'b1;
    wait_rise();
    measure(1'b0, 8'h00, hi, n);
    check(hi == 1, "R1 R5 reset compare high clocks", hi, 1);
    check(n == 256, "R1 R2 reset period", n, 256);

    // Full compare sweep; each value written mid-period applies next period (R7)
    prev_c = 0;
    for (int k = 0; k <= 256; k++) begin
      measure(k < 256, 8'(k), hi, n);
      if (prev_c == 0)
        check(hi == 1, "R5 compare 00h high clocks", hi, 1);
      else if (prev_c == 255)
        check(hi == 255, "R6 compare FFh high clocks", hi, 255);
      else
        check(hi == high_counts(prev_c), "R4 R7 sweep high clocks", hi, high_counts(prev_c));
      check(n == 256, "R2 sweep period", n, 256);
      prev_c = k;
    end

    // Prescaler reload values (R3, R9 reload select)
    for (int t = 0; t < 4; t++) begin
      int r, c;
      r = (t == 0) ? 1 : (t == 1) ? 2 : (t == 2) ? 3 : 6;
      c = (t == 0) ? 8'h80 : (t == 1) ? 0 : (t == 2) ? 8'hFF : 8'h21;
      @(negedge clk); enable = 1'b0;
      reg_write(1'b1, 8'(r));
      reg_write(1'b0, 8'(c));
      @(negedge clk); prev = pwm_out;
      enable = 1'b1;
      wait_rise();
      measure(1'b0, 8'h00, hi, n);
      measure(1'b0, 8'h00, hi, n);
      check(n == 256 * (r + 1), "R3 prescaled period", n, 256 * (r + 1));
      check(hi == high_counts(c) * (r + 1), "R3 R4 prescaled high clocks", hi, high_counts(c) * (r + 1));
    end

    // Disable mid-period, then clean restart (R8, R9, R10, R7)
    @(negedge clk); enable = 1'b0;
    reg_write(1'b1, 8'h00);
    reg_write(1'b0, 8'h80);
    @(negedge clk); prev = pwm_out;
    enable = 1'b1;
    wait_rise();
    repeat (100) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(pwm_out == 1'b0, "R10 output low one clock after disable", pwm_out, 0);
    reg_write(1'b0, 8'd10);
    wr_sel = 1'b0; wr_data = 8'hC0; wr_en = 1'b0;
    begin
      int seen_hi = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (pwm_out) seen_hi++;
      end
      check(seen_hi == 0, "R8 output held low while disabled", seen_hi, 0);
    end
    enable = 1'b1;
    begin
      int first_run = 0, total_hi = 0;
      bit in_run = 1'b1;
      for (int i = 1; i <= 256; i++) begin
        @(negedge clk);
        if (pwm_out) total_hi++;
        if (in_run && pwm_out) first_run++; else in_run = 1'b0;
      end
      check(first_run == 10, "R8 R9 R10 restart high run from count 0", first_run, 10);
      check(total_hi == 10, "R7 R9 compare written while disabled", total_hi, 10);
      @(negedge clk);
      check(pwm_out == 1'b1, "R2 next period starts after 256 clocks", pwm_out, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule